// File: doc/BRIEF.md
# T1 Receive Timing Strobe Generator

This block turns a single frame-alignment pulse from an upstream framer into a set of per-bit timing strobes for one T1 receive path. Every output changes only on the rising edge of the recovered receive clock. Once the block has been aligned, it counts the bit position within a 193-bit frame, the channel, and the frame number within the multiframe. It decodes four output pins from those counts: a frame sync, a multiframe sync, and two shared pins. The shared pins carry either a channel clock and a per-channel block signal, or a link clock and link data.

The control is a small position state machine with four named states. `ST_HUNT` is the state before any alignment pulse has arrived, and all strobes stay low in it. `ST_FBIT` is the framing-bit cycle. `ST_PAY` covers payload bits 1 to 191. `ST_LAST` is payload bit 192, which is also the least significant bit of channel 24. The transitions are:

- hunt-to-fbit on the alignment pulse;
- fbit-to-pay unconditionally;
- pay-to-last when bit 191 is current;
- last-to-fbit at the end of the frame;
- a resync transition into `ST_FBIT` from any state whenever the alignment pulse is seen.

The frame counter advances on last-to-fbit and wraps by multiframe length. The overhead bit of each link-carrying frame is captured during its framing-bit cycle.

Top module: `t1_rx_strobe_gen`

## Requirements
- R1: After reset, and until the first cycle in which `align_in` is sampled high, all four outputs are low.
- R2: If `align_in` is high in cycle t, then cycle t+1 is the framing bit (position 0) of frame 1, and positions then advance 0..192 with one bit per clock. `frm_sync` is high for the framing bit of every frame.
- R3: When `link_sel`=0, `chclk_lclk` is high exactly at positions 8k (k=1..24), which are the last, least significant bit of each 8-bit channel. The channel's most significant bit is first.
- R4: When `link_sel`=0, `chblk_ldat` equals `ch_mask[k-1]` during positions 8k-7 to 8k (channel k). It is low at the framing bit.
- R5: When `sig_dw_en`=1 and the frame number is a multiple of 6, `frm_sync` is also high at position 1, which makes it two clocks wide. Otherwise it is high only at position 0.
- R6: `fmt_sel`=0 (D4) gives a 12-frame multiframe. Any other code gives 24 frames. `mf_sync` is high only at the framing bit of frame 1.
- R7: `link_sel`=1 switches the two shared outputs to the link clock and the link data. `link_sel`=0 selects the channel clock and channel block.
- R8: The link clock is high at position 192 of each link frame. In D4 (`fmt_sel`=0) the link frames are the even frames. In ZBTSI (`fmt_sel`=2) they are frames 1,5,9,... In ESF (`fmt_sel`=1 or 3) they are the odd frames.
- R9: The link data is the `rx_data` value sampled in the framing-bit cycle of the most recent link frame. It is presented from the next cycle on, so it is valid when the link clock is high, one clock before the next frame starts. It is low before the first capture.
- R10: An `align_in` pulse in any state restarts the count, so the next cycle is position 0 of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| align_in | input | 1 | Alignment pulse: the next cycle is the framing bit of frame 1 |
| rx_data | input | 1 | Received serial data bit |
| fmt_sel | input | 2 | 0 = D4, 1 = ESF, 2 = ZBTSI, 3 = ESF |
| sig_dw_en | input | 1 | Enables the double-wide frame sync on signaling frames |
| link_sel | input | 1 | 0 = channel clock/block on shared pins, 1 = link clock/data |
| ch_mask | input | 24 | Per-channel block level; bit k-1 belongs to channel k |
| chclk_lclk | output | 1 | Channel clock or link clock |
| chblk_ldat | output | 1 | Channel block or link data |
| frm_sync | output | 1 | Frame sync pulse |
| mf_sync | output | 1 | Multiframe sync pulse |

## Verification
The assertions assume that `fmt_sel` and `sig_dw_en` change only in the same cycle as an `align_in` pulse. They also assume `align_in` is a single-cycle strobe. Under those conditions the frame counter's wrap and the double-wide rule stay consistent within one multiframe. The stimulus follows the same discipline: a seeded random stream drives `rx_data`, occasional resyncs at random positions, mask patterns and `link_sel` changes, and the bench changes the format only together with a resync. Directed segments add the pre-alignment period, all-ones, all-zeros and alternating masks, and a pass through every format code.

// File: rtl/t1s_pkg.sv
package t1s_pkg;

    typedef enum logic [1:0] {
        FMT_D4  = 2'd0,
        FMT_ESF = 2'd1,
        FMT_ZBT = 2'd2,
        FMT_ALT = 2'd3
    } fmt_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FBIT = 2'd1,
        ST_PAY  = 2'd2,
        ST_LAST = 2'd3
    } pos_state_t;

    function automatic logic [5:0] mf_length(input fmt_t f, input int d4_len, input int esf_len);
        mf_length = (f == FMT_D4) ? 6'(d4_len) : 6'(esf_len);
    endfunction

    function automatic logic carries_link(input fmt_t f, input logic [5:0] frm);
        unique case (f)
            FMT_D4:  carries_link = (frm[0] == 1'b0);
            FMT_ZBT: carries_link = (frm[1:0] == 2'b01);
            default: carries_link = (frm[0] == 1'b1);
        endcase
    endfunction

endpackage

// File: rtl/t1s_bit_fsm.sv
module t1s_bit_fsm
    import t1s_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8,
    localparam int FRAME_BITS = CHANNELS * CH_BITS + 1,
    localparam int POS_W = $clog2(FRAME_BITS),
    localparam int CH_W  = $clog2(CHANNELS),
    localparam int BIC_W = $clog2(CH_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_in,
    output pos_state_t       st,
    output logic [POS_W-1:0] pos,
    output logic [CH_W-1:0]  chn,
    output logic             ch_lsb,
    output logic             in_pay,
    output logic             is_fbit,
    output logic             frame_end
);

    pos_state_t       st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [CH_W-1:0]  chn_q, chn_d;
    logic [BIC_W-1:0] bic_q, bic_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            pos_q <= '0;
            chn_q <= '0;
            bic_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
            chn_q <= chn_d;
            bic_q <= bic_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        chn_d = chn_q;
        bic_d = bic_q;
        unique case (st_q)
            ST_HUNT: begin
                st_d = ST_HUNT;
            end
            ST_FBIT: begin
                st_d  = ST_PAY;
                pos_d = POS_W'(1);
                chn_d = '0;
                bic_d = '0;
            end
            ST_PAY: begin
                pos_d = pos_q + POS_W'(1);
                if (bic_q == BIC_W'(CH_BITS - 1)) begin
                    bic_d = '0;
                    chn_d = chn_q + CH_W'(1);
                end else begin
                    bic_d = bic_q + BIC_W'(1);
                end
                if (pos_q == POS_W'(FRAME_BITS - 2))
                    st_d = ST_LAST;
            end
            ST_LAST: begin
                st_d  = ST_FBIT;
                pos_d = '0;
                chn_d = '0;
                bic_d = '0;
            end
            default: st_d = ST_HUNT;
        endcase
        if (align_in) begin
            st_d  = ST_FBIT;
            pos_d = '0;
            chn_d = '0;
            bic_d = '0;
        end
    end

    always_comb begin
        st        = st_q;
        pos       = pos_q;
        chn       = chn_q;
        in_pay    = (st_q == ST_PAY) || (st_q == ST_LAST);
        is_fbit   = (st_q == ST_FBIT);
        frame_end = (st_q == ST_LAST);
        ch_lsb    = in_pay && (bic_q == BIC_W'(CH_BITS - 1));
    end

    // R10: resync lands on the framing bit
    p_align_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        align_in |=> (st_q == ST_FBIT) && (pos_q == '0));
    // R2: the last bit is always followed by a framing bit
    p_last_to_fbit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LAST) |=> (st_q == ST_FBIT));
    // R1: without an alignment pulse the hunt state persists
    p_hunt_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT && !align_in) |=> (st_q == ST_HUNT));
    // R3: channel LSB agrees with the frame position
    p_lsb_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ch_lsb |-> ((32'(pos_q) % CH_BITS) == 0) && (pos_q != '0));

endmodule

// File: rtl/t1s_frame_ctr.sv
module t1s_frame_ctr
    import t1s_pkg::*;
#(
    parameter int D4_FRAMES  = 12,
    parameter int ESF_FRAMES = 24,
    parameter int SIG_EVERY  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       adv,
    input  fmt_t       fmt,
    output logic [5:0] frm,
    output logic       sig_frame,
    output logic       link_frame,
    output logic       first
);

    logic [5:0] frm_q;
    logic [5:0] mflen;

    always_comb mflen = mf_length(fmt, D4_FRAMES, ESF_FRAMES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frm_q <= 6'd1;
        else if (load)
            frm_q <= 6'd1;
        else if (adv)
            frm_q <= (frm_q >= mflen) ? 6'd1 : frm_q + 6'd1;
    end

    always_comb begin
        frm        = frm_q;
        sig_frame  = ((32'(frm_q) % SIG_EVERY) == 0);
        link_frame = carries_link(fmt, frm_q);
        first      = (frm_q == 6'd1);
    end

    // R6: a D4 multiframe wraps after frame 12
    p_d4_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && fmt == FMT_D4 && frm_q == 6'(D4_FRAMES)) |=> (frm_q == 6'd1));
    // R10: a resync restarts at frame 1
    p_load_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frm_q == 6'd1));

endmodule

// File: rtl/t1s_link_cap.sv
module t1s_link_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic rx_data,
    output logic ldat
);

    logic ldat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ldat_q <= 1'b0;
        else if (cap_en)
            ldat_q <= rx_data;
    end

    assign ldat = ldat_q;

    // R9: link data follows the captured bit
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (ldat_q == $past(rx_data)));

endmodule

// File: rtl/t1_rx_strobe_gen.sv
module t1_rx_strobe_gen
    import t1s_pkg::*;
#(
    parameter int CHANNELS   = 24,
    parameter int CH_BITS    = 8,
    parameter int D4_FRAMES  = 12,
    parameter int ESF_FRAMES = 24,
    parameter int SIG_EVERY  = 6,
    localparam int FRAME_BITS = CHANNELS * CH_BITS + 1,
    localparam int POS_W = $clog2(FRAME_BITS),
    localparam int CH_W  = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                align_in,
    input  logic                rx_data,
    input  logic [1:0]          fmt_sel,
    input  logic                sig_dw_en,
    input  logic                link_sel,
    input  logic [CHANNELS-1:0] ch_mask,
    output logic                chclk_lclk,
    output logic                chblk_ldat,
    output logic                frm_sync,
    output logic                mf_sync
);

    pos_state_t       st;
    logic [POS_W-1:0] pos;
    logic [CH_W-1:0]  chn;
    logic             ch_lsb, in_pay, is_fbit, frame_end;
    logic [5:0]       frm;
    logic             sig_frame, link_frame, first;
    logic             ldat;
    fmt_t             fmt;

    assign fmt = fmt_t'(fmt_sel);

    t1s_bit_fsm #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_bits (
        .clk(clk), .rst_n(rst_n), .align_in(align_in),
        .st(st), .pos(pos), .chn(chn), .ch_lsb(ch_lsb),
        .in_pay(in_pay), .is_fbit(is_fbit), .frame_end(frame_end)
    );

    t1s_frame_ctr #(.D4_FRAMES(D4_FRAMES), .ESF_FRAMES(ESF_FRAMES), .SIG_EVERY(SIG_EVERY)) u_frames (
        .clk(clk), .rst_n(rst_n), .load(align_in), .adv(frame_end), .fmt(fmt),
        .frm(frm), .sig_frame(sig_frame), .link_frame(link_frame), .first(first)
    );

    t1s_link_cap u_link (
        .clk(clk), .rst_n(rst_n), .cap_en(is_fbit && link_frame),
        .rx_data(rx_data), .ldat(ldat)
    );

    logic chclk, chblk, lclk;

    always_comb begin
        chclk = ch_lsb;
        chblk = in_pay && ch_mask[chn];
        lclk  = frame_end && link_frame;
        frm_sync = is_fbit ||
                   (sig_dw_en && sig_frame && st == ST_PAY && pos == POS_W'(1));
        mf_sync  = is_fbit && first;
        chclk_lclk = link_sel ? lclk : chclk;   // R7
        chblk_ldat = link_sel ? ldat : chblk;   // R7
    end

    // R1: nothing toggles before alignment
    p_quiet_hunt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT) |-> !frm_sync && !mf_sync && !chclk_lclk && !chblk_ldat);
    // R5: a frame sync outside the framing bit only in the double-wide case
    p_dw_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_sync && !is_fbit) |-> (sig_dw_en && sig_frame && pos == POS_W'(1)));
    // R6: multiframe sync coincides with frame sync
    p_mf_in_f_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync |-> frm_sync);
    // R8: the link clock sits in the last bit of a frame
    p_lclk_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sel && chclk_lclk) |-> frame_end);

endmodule

// File: tb/tb_t1_rx_strobe_gen.sv
module tb_t1_rx_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        align_in, rx_data, sig_dw_en, link_sel;
    logic [1:0]  fmt_sel;
    logic [23:0] ch_mask;
    logic        chclk_lclk, chblk_ldat, frm_sync, mf_sync;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    t1_rx_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .align_in(align_in), .rx_data(rx_data),
        .fmt_sel(fmt_sel), .sig_dw_en(sig_dw_en), .link_sel(link_sel),
        .ch_mask(ch_mask), .chclk_lclk(chclk_lclk), .chblk_ldat(chblk_ldat),
        .frm_sync(frm_sync), .mf_sync(mf_sync)
    );

    // reference model state, meaning: position of the current output cycle
    bit m_al;
    int m_pos, m_frm, since_sync;
    bit m_ldat;

    function automatic int mf_len(input logic [1:0] f);
        return (f == 2'd0) ? 12 : 24;
    endfunction

    function automatic bit link_fr(input logic [1:0] f, input int fr);
        if (f == 2'd0) return (fr % 2) == 0;
        if (f == 2'd2) return (fr % 4) == 1;
        return (fr % 2) == 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_al = 0; m_pos = 0; m_frm = 1; m_ldat = 0; since_sync = 1000;
        end else begin
            if (m_al && m_pos == 0 && link_fr(fmt_sel, m_frm)) m_ldat = rx_data;
            if (align_in) begin
                m_al = 1; m_pos = 0; m_frm = 1; since_sync = 0;
            end else if (m_al) begin
                if (m_pos == 192) begin
                    m_pos = 0;
                    m_frm = (m_frm >= mf_len(fmt_sel)) ? 1 : m_frm + 1;
                end else m_pos = m_pos + 1;
            end
            since_sync = since_sync + 1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b (pos=%0d frame=%0d)", tag, act, exp, m_pos, m_frm);
        end
    endtask

    task automatic check_all();
        bit e_ch, e_blk, e_fs, e_ms, e_lclk;
        e_ch   = m_al && m_pos != 0 && (m_pos % 8) == 0;
        e_blk  = m_al && m_pos != 0 && ch_mask[(m_pos - 1) / 8];
        e_fs   = m_al && (m_pos == 0 || (sig_dw_en && (m_frm % 6) == 0 && m_pos == 1));
        e_ms   = m_al && m_pos == 0 && m_frm == 1;
        e_lclk = m_al && m_pos == 192 && link_fr(fmt_sel, m_frm);
        if (!m_al) begin
            chk("R1", chclk_lclk, 1'b0); chk("R1", chblk_ldat, 1'b0);
            chk("R1", frm_sync, 1'b0);   chk("R1", mf_sync, 1'b0);
        end else begin
            // R7: shared pins follow link_sel
            if (link_sel) begin
                chk("R8", chclk_lclk, e_lclk);
                chk("R9", chblk_ldat, m_ldat);
            end else begin
                chk("R3", chclk_lclk, e_ch);
                chk("R4", chblk_ldat, e_blk);
            end
            if (since_sync == 1) chk("R10", frm_sync, 1'b1);
            else if (m_pos == 1) chk("R5", frm_sync, e_fs);
            else chk("R2", frm_sync, e_fs);
            chk("R6", mf_sync, e_ms);
        end
    endtask

    initial begin
        int fmt_step = 0;
        void'($urandom(32'd20240));
        rst_n = 0; align_in = 0; rx_data = 0; fmt_sel = 0;
        sig_dw_en = 0; link_sel = 0; ch_mask = '1;
        repeat (3) begin
            @(negedge clk);
            check_all();
        end
        rst_n = 1;
        // R1: random data, no alignment yet
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            check_all();
            rx_data  = 1'($urandom);
            link_sel = (i % 50) < 25;
        end
        align_in = 1;
        @(negedge clk);
        check_all();
        align_in = 0;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            check_all();
            align_in = 0;
            rx_data  = 1'($urandom);
            if (i % 997 == 0) begin
                unique case ((i / 997) % 4)
                    0: ch_mask = '1;
                    1: ch_mask = '0;
                    2: ch_mask = 24'h555555;
                    default: ch_mask = 24'($urandom);
                endcase
            end
            if (i % 613 == 0) link_sel = ~link_sel;
            if (i % 10000 == 5000) begin
                fmt_step++;
                fmt_sel   = 2'(fmt_step);
                sig_dw_en = (fmt_step % 2) == 1;
                align_in  = 1;
            end else if ($urandom_range(0, 4999) == 0) begin
                fmt_sel   = 2'($urandom);
                sig_dw_en = 1'($urandom);
                align_in  = 1;
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule